// File: doc/BRIEF.md
# Victim Line Buffer

This block sits next to a direct-mapped cache and keeps a handful of recently discarded lines. When the primary cache evicts a line, the line goes into this buffer. When the primary cache misses, it probes the buffer with the full line address. On a hit, the buffer returns the line so the lower memory level is not accessed. In the same step the primary cache's current occupant of that set can be handed over, and it takes the freed entry.

The buffer is fully associative. Every entry stores a full line address (set index bits included), one line of data, a valid bit and a dirty bit, and each entry has its own comparator. Placement uses the lowest-numbered free entry first. When no entry is free, the least recently used entry is replaced. A replaced entry leaves through a single-slot writeback port toward the next level, and only if it is dirty.

The eviction input and the writeback output use valid/ready handshakes. A transfer happens on a clock edge where both valid and ready are high. The eviction input drops ready while a writeback is waiting, and also in any cycle where a probe is presented. The writeback output holds its valid, address and data unchanged until the downstream side raises ready. The probe is always accepted and has no ready. Its result is a one-cycle pulse that cannot be stalled.

Top module: `victim_cache`

## Requirements
- R1: After reset all entries are empty, `resp_valid` and `wb_valid` are 0 and `evict_ready` is 1.
- R2: A line accepted on the eviction port is returned with `resp_hit`=1 and its data by a later probe of the same line address.
- R3: Every probe produces exactly one `resp_valid` pulse, in the cycle after the probe. A probe of an absent address gives `resp_hit`=0 and changes no entry.
- R4: On a probe hit with `swap_valid`=1, the hit entry is replaced by the swap line. Afterwards the swapped-in address hits with its data, and the old address misses.
- R5: On a probe hit with `swap_valid`=0, the hit entry is freed. A later probe of that address misses, and the next eviction fills the freed entry without a writeback.
- R6: While any entry is free, an accepted eviction fills the lowest-numbered free entry and raises no writeback.
- R7: With all entries valid, an accepted eviction replaces the entry least recently filled or swapped into.
- R8: A replaced entry raises `wb_valid` one cycle after the eviction is accepted, carrying its address and data, only if its dirty bit is 1. A clean replaced entry is dropped silently.
- R9: While `wb_valid`=1 and `wb_ready`=0, `wb_addr` and `wb_data` stay stable and `evict_ready` is 0. The slot clears on the edge where `wb_ready` is 1.
- R10: `evict_ready` is 0 in any cycle with `lookup_valid`=1. An eviction offered then is not stored.
- R11: `resp_dirty` returns the stored dirty bit of the hit entry, and is 0 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_valid | input | 1 | Evicted line offered |
| evict_ready | output | 1 | Buffer accepts the evicted line |
| evict_addr | input | ADDR_W | Full line address of the evicted line |
| evict_data | input | LINE_W | Evicted line data |
| evict_dirty | input | 1 | Evicted line is modified |
| lookup_valid | input | 1 | Primary-miss probe, always accepted |
| lookup_addr | input | ADDR_W | Probe line address |
| swap_valid | input | 1 | Primary has a line to hand over on a hit |
| swap_addr | input | ADDR_W | Address of the line handed over |
| swap_data | input | LINE_W | Data of the line handed over |
| swap_dirty | input | 1 | Handed-over line is modified |
| resp_valid | output | 1 | Probe result valid (one cycle) |
| resp_hit | output | 1 | Probe found the line |
| resp_data | output | LINE_W | Line data on a hit |
| resp_dirty | output | 1 | Dirty bit of the returned line |
| wb_valid | output | 1 | Displaced dirty line waiting |
| wb_ready | input | 1 | Lower level takes the line |
| wb_addr | output | ADDR_W | Displaced line address |
| wb_data | output | LINE_W | Displaced line data |

## Verification
A probe driven before edge k has its result on `resp_valid`, `resp_hit`, `resp_data` and `resp_dirty` just after edge k. The bench reads these at the following falling edge and checks one cycle later that the pulse has ended. An eviction accepted at edge k shows its writeback just after edge k. The bench holds `wb_ready` low for an extra cycle to confirm the slot is stable and that `evict_ready` is low, then releases it and checks the slot is empty one edge later. Entry state is always observed through later probes and the writeback port, compared against a model of free-first, least-recently-used placement kept in the bench.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_FILL = 2'd1,
    OP_SWAP = 2'd2,
    OP_DROP = 2'd3
  } vc_op_e;
endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int N      = 4,
  parameter int ADDR_W = 26
) (
  input  logic [N-1:0]             ent_valid,
  input  logic [N-1:0][ADDR_W-1:0] ent_tag,
  input  logic [ADDR_W-1:0]        probe,
  output logic [N-1:0]             hit_vec
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ent_valid[g] && (ent_tag[g] == probe);
  end
endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 touch_en,
  input  logic [$clog2(N)-1:0] touch_idx,
  output logic [$clog2(N)-1:0] lru_idx
);
  localparam int IW = $clog2(N);
  localparam logic [IW-1:0] OLDEST = IW'(N - 1);

  logic [N-1:0][IW-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < N; j++) age[j] <= IW'(j);
    end else if (touch_en) begin
      for (int j = 0; j < N; j++) begin
        if (IW'(j) == touch_idx) age[j] <= '0;
        else if (age[j] < age[touch_idx]) age[j] <= age[j] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int j = 0; j < N; j++)
      if (age[j] == OLDEST) lru_idx = IW'(j);
  end

  logic [N-1:0] is_oldest;
  for (genvar g = 0; g < N; g++) begin : g_old
    assign is_oldest[g] = (age[g] == OLDEST);
  end

  // R7
  lru_single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_oldest) == 1);
endmodule

// File: rtl/vc_wb.sv
module vc_wb #(
  parameter int ADDR_W = 26,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LINE_W-1:0] load_data,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
    end else if (load) begin
      wb_valid <= 1'b1;
    end else if (wb_ready) begin
      wb_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      wb_addr <= load_addr;
      wb_data <= load_data;
    end
  end

  // R9
  wb_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));
endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
  parameter int N      = 4,
  parameter int ADDR_W = 26,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evict_valid,
  output logic              evict_ready,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [LINE_W-1:0] evict_data,
  input  logic              evict_dirty,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  input  logic              swap_valid,
  input  logic [ADDR_W-1:0] swap_addr,
  input  logic [LINE_W-1:0] swap_data,
  input  logic              swap_dirty,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [LINE_W-1:0] resp_data,
  output logic              resp_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data
);
  import vc_pkg::*;
  localparam int IW = $clog2(N);

  logic [N-1:0]             ent_valid;
  logic [N-1:0]             ent_dirty;
  logic [N-1:0][ADDR_W-1:0] ent_tag;
  logic [N-1:0][LINE_W-1:0] ent_data;

  logic [N-1:0] hit_vec;
  logic         any_hit, any_free, wb_load, touch_en;
  logic [IW-1:0] hit_idx, free_idx, lru_idx, fill_idx, touch_idx;
  vc_op_e       op;

  vc_match #(.N(N), .ADDR_W(ADDR_W)) u_match (
    .ent_valid(ent_valid), .ent_tag(ent_tag), .probe(lookup_addr), .hit_vec(hit_vec)
  );

  vc_lru #(.N(N)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx), .lru_idx(lru_idx)
  );

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int j = N - 1; j >= 0; j--) begin
      if (hit_vec[j])    hit_idx  = IW'(j);
      if (!ent_valid[j]) free_idx = IW'(j);
    end
  end

  assign any_hit     = |hit_vec;
  assign any_free    = ~&ent_valid;
  assign evict_ready = !wb_valid && !lookup_valid;
  assign fill_idx    = any_free ? free_idx : lru_idx;

  always_comb begin
    if (evict_valid && evict_ready)  op = OP_FILL;
    else if (lookup_valid && any_hit) op = swap_valid ? OP_SWAP : OP_DROP;
    else                              op = OP_IDLE;
  end

  assign wb_load   = (op == OP_FILL) && !any_free && ent_dirty[lru_idx];
  assign touch_en  = (op == OP_FILL) || (op == OP_SWAP);
  assign touch_idx = (op == OP_FILL) ? fill_idx : hit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      ent_dirty <= '0;
    end else begin
      case (op)
        OP_FILL: begin
          ent_valid[fill_idx] <= 1'b1;
          ent_dirty[fill_idx] <= evict_dirty;
        end
        OP_SWAP: ent_dirty[hit_idx] <= swap_dirty;
        OP_DROP: ent_valid[hit_idx] <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (op == OP_FILL) begin
      ent_tag[fill_idx]  <= evict_addr;
      ent_data[fill_idx] <= evict_data;
    end else if (op == OP_SWAP) begin
      ent_tag[hit_idx]  <= swap_addr;
      ent_data[hit_idx] <= swap_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_dirty <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= lookup_valid;
      resp_hit   <= lookup_valid && any_hit;
      resp_dirty <= lookup_valid && any_hit && ent_dirty[hit_idx];
      resp_data  <= ent_data[hit_idx];
    end
  end

  vc_wb #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_wb (
    .clk(clk), .rst_n(rst_n), .load(wb_load),
    .load_addr(ent_tag[lru_idx]), .load_data(ent_data[lru_idx]),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R3
  resp_follows_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> resp_valid);
  // R11
  resp_dirty_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_dirty |-> (resp_hit && resp_valid));
  // R8
  wb_from_accepted_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(evict_valid && evict_ready));
  // R10
  no_evict_during_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |-> !evict_ready);
endmodule

// File: tb/victim_cache_test.sv
module victim_cache_test;
  localparam int N = 4, AW = 8, LW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evict_valid = 0, evict_dirty = 0, lookup_valid = 0, swap_valid = 0, swap_dirty = 0, wb_ready = 0;
  logic [AW-1:0] evict_addr = '0, lookup_addr = '0, swap_addr = '0;
  logic [LW-1:0] evict_data = '0, swap_data = '0;
  logic evict_ready, resp_valid, resp_hit, resp_dirty, wb_valid;
  logic [LW-1:0] resp_data, wb_data;
  logic [AW-1:0] wb_addr;

  int tests = 0, fails = 0;
  bit done = 0;

  bit          mv[N];
  bit          mdt[N];
  logic [AW-1:0] ma[N];
  logic [LW-1:0] md[N];
  int          mage[N];

  always #4 clk = ~clk;

  victim_cache #(.N(N), .ADDR_W(AW), .LINE_W(LW)) uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mfind(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (mv[i] && ma[i] == a) return i;
    return -1;
  endfunction

  function automatic void mtouch(input int t);
    int old = mage[t];
    for (int j = 0; j < N; j++) begin
      if (j == t) mage[j] = 0;
      else if (mage[j] < old) mage[j] = mage[j] + 1;
    end
  endfunction

  task automatic do_evict(input logic [AW-1:0] a, input logic [LW-1:0] d, input bit dt, input string req);
    int slot = -1;
    bit exp_wb;
    logic [AW-1:0] wa;
    logic [LW-1:0] wd;
    @(negedge clk);
    evict_valid = 1; evict_addr = a; evict_data = d; evict_dirty = dt;
    chk(evict_ready == 1'b1, "R9", evict_ready, 1);
    for (int i = N - 1; i >= 0; i--) if (!mv[i]) slot = i;
    exp_wb = 0;
    if (slot < 0) begin
      for (int i = 0; i < N; i++) if (mage[i] == N - 1) slot = i;
      exp_wb = mdt[slot];
      wa = ma[slot]; wd = md[slot];
    end
    mv[slot] = 1; ma[slot] = a; md[slot] = d; mdt[slot] = dt;
    mtouch(slot);
    @(posedge clk);
    @(negedge clk);
    evict_valid = 0;
    chk(wb_valid == exp_wb, req, wb_valid, exp_wb);
    if (exp_wb) begin
      chk(wb_addr == wa, "R8", wb_addr, wa);
      chk(wb_data == wd, "R8", wb_data, wd);
      chk(evict_ready == 1'b0, "R9", evict_ready, 0);
      @(posedge clk);
      @(negedge clk);
      chk(wb_valid && wb_addr == wa && wb_data == wd, "R9", {wb_valid, wb_addr}, {1'b1, wa});
      wb_ready = 1;
      @(posedge clk);
      @(negedge clk);
      wb_ready = 0;
      chk(wb_valid == 1'b0, "R9", wb_valid, 0);
    end
  endtask

  task automatic do_lookup(input logic [AW-1:0] a, input bit sv, input logic [AW-1:0] sa,
                           input logic [LW-1:0] sd, input bit sdt, input string req);
    int i;
    @(negedge clk);
    lookup_valid = 1; lookup_addr = a;
    swap_valid = sv; swap_addr = sa; swap_data = sd; swap_dirty = sdt;
    i = mfind(a);
    @(posedge clk);
    @(negedge clk);
    lookup_valid = 0; swap_valid = 0;
    chk(resp_valid == 1'b1, "R3", resp_valid, 1);
    chk(resp_hit == (i >= 0), req, resp_hit, (i >= 0));
    if (i >= 0) begin
      chk(resp_data == md[i], req, resp_data, md[i]);
      chk(resp_dirty == mdt[i], "R11", resp_dirty, mdt[i]);
      if (sv) begin
        ma[i] = sa; md[i] = sd; mdt[i] = sdt;
        mtouch(i);
      end else mv[i] = 0;
    end else begin
      chk(resp_dirty == 1'b0, "R11", resp_dirty, 0);
    end
    @(posedge clk);
    @(negedge clk);
    chk(resp_valid == 1'b0, "R3", resp_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; mdt[i] = 0; mage[i] = i; ma[i] = '0; md[i] = '0; end
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(resp_valid == 0 && wb_valid == 0, "R1", {resp_valid, wb_valid}, 0);
    chk(evict_ready == 1, "R1", evict_ready, 1);
    for (int k = 0; k < 8; k++) do_lookup(AW'(8'h40 + k), 0, '0, '0, 0, "R1");

    // R6 fill every entry, no writeback
    for (int k = 0; k < N; k++) do_evict(AW'(8'h10 + k), LW'(16'hA000 + k * 7), k[0], "R6");
    // R2 R11 each hits; R4 swap in a new line
    for (int k = 0; k < N; k++) do_lookup(AW'(8'h10 + k), 1, AW'(8'h20 + k), LW'(16'hB000 + k), ~k[0], "R4");
    for (int k = 0; k < N; k++) do_lookup(AW'(8'h10 + k), 0, '0, '0, 0, "R4");
    for (int k = 0; k < N; k++) do_lookup(AW'(8'h20 + k), 1, AW'(8'h28 + k), LW'(16'hC100 + k), 1, "R2");

    // R7 R8 replacement sweep with mixed dirty bits
    for (int k = 0; k < 10; k++) do_evict(AW'(8'h60 + k), LW'(16'hD000 + k * 3), (k % 3) != 0, "R8");
    for (int k = 0; k < 10; k++) do_lookup(AW'(8'h60 + k), 1, AW'(8'h80 + k), LW'(16'hE000 + k), k[1], "R7");
    for (int k = 0; k < 6; k++) do_evict(AW'(8'h90 + k), LW'(16'hF000 + k), k[0], "R7");

    // R5 drop without swap, then refill the freed entry
    do_lookup(AW'(8'h93), 0, '0, '0, 0, "R5");
    do_lookup(AW'(8'h93), 0, '0, '0, 0, "R5");
    do_evict(AW'(8'hA5), LW'(16'h1234), 1, "R5");
    do_lookup(AW'(8'hA5), 1, AW'(8'hA6), LW'(16'h4321), 0, "R5");

    // R10 eviction offered alongside a probe is refused
    @(negedge clk);
    lookup_valid = 1; lookup_addr = 8'hEE; evict_valid = 1; evict_addr = 8'hEF; evict_data = 16'h5555;
    #1 chk(evict_ready == 1'b0, "R10", evict_ready, 0);
    @(posedge clk);
    @(negedge clk);
    lookup_valid = 0; evict_valid = 0;
    do_lookup(AW'(8'hEF), 0, '0, '0, 0, "R10");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule